// File: doc/BRIEF.md
# Receive Frame Header Aligner

This block sits on the receive side of a serial link. A deserializer hands it one 40-bit word per clock, and the word boundary can sit at any bit position relative to the 120-bit frames on the line. The aligner looks for the 4-bit frame header and slides its view of the bit stream one bit at a time until the header lines up. It then watches the header of each following frame and declares the link locked only after a long unbroken run of good headers.

The aligner keeps the previous word next to the current one and selects any 40-bit window from the pair. Once it is locked, it labels each aligned word with its position inside the frame and marks the first word of every frame. A downstream stage uses the position index as the write address to gather three words into one 120-bit frame. After a short burst of bad headers the aligner drops lock and starts searching again. Decoding of the frame contents is left to later stages.

Top module: `frame_aligner`

## Requirements
- R1: While reset is asserted, `locked`, `frame_start`, `word_idx` and `al_word` are all zero.
- R2: Bit 0 of every input word is the earliest bit on the line. With slip offset s, the word registered out after input word t is stream bits 40*(t-1)+s upward, where the previous word is zero after reset. A header matches when `al_word[3:0]` equals 4'b1010, with bit 0 as the first header bit received.
- R3: While searching, every word is tested. On a mismatch the slip offset grows by one and wraps from 39 to 0, so the next output word moves by one more bit.
- R4: The first matching word while searching becomes word 0 of a frame, and the aligner moves on to confirmation with its good-header count cleared.
- R5: During confirmation only word 0 of each frame is tested. After the first match, 32 further consecutive good headers are needed. `locked` rises in the same cycle as the output of the word that carries the 32nd of them, which is 96 words after the first match.
- R6: A bad header during confirmation sends the aligner back to searching with its count cleared, so it does not lock at the original time. It locks later on good headers.
- R7: While locked, `word_idx` steps 0, 1, 2, 0 and so on. `frame_start` is high exactly with index 0. The three words {idx2, idx1, idx0} form a transmitted 120-bit frame, with frame bit 0 in bit 0 of index 0.
- R8: While locked, lock is lost only at the fourth consecutive bad header. Three bad headers followed by a good one keep the lock, and the good one clears the run.
- R9: Outside the search state the slip offset never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 40 | Word from the deserializer, bit 0 earliest |
| al_word | output | 40 | Bit-aligned word, registered |
| word_idx | output | 2 | Position of `al_word` inside the frame (write address) |
| frame_start | output | 1 | High with the first word of a frame while locked |
| locked | output | 1 | Link lock status |

## Verification
Each input word goes through one register, so `al_word`, `word_idx` and `frame_start` for word t appear after the rising edge that captures word t. The bench drives each word on a falling edge and reads the results on the next falling edge. A reference search over the stream model gives the first matching word t0. From there the bench expects `locked` low after word t0+95, high after word t0+96, and the first `frame_start` on word t0+99. Bad headers are placed on known frames, and loss of lock is sampled on the exact word that carries the fourth bad header. Random payload runs rebuild frames from the indexed words and compare them with the transmitted ones.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } fa_state_e;
endpackage

// File: rtl/fa_slip_shifter.sv
module fa_slip_shifter #(
  parameter int W      = 40,
  parameter int SLIP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      rx_word,
  input  logic [SLIP_W-1:0] slip,
  output logic [W-1:0]      aligned
);
  logic [W-1:0]    prev_q;
  logic [2*W-1:0]  pair;
  logic [SLIP_W:0] base;

  // previous word holds earlier stream bits, so it sits in the low half
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= rx_word;
  end

  always_comb begin
    pair    = {rx_word, prev_q};
    base    = {1'b0, slip};
    aligned = pair[base +: W];
  end
endmodule

// File: rtl/fa_hdr_match.sv
module fa_hdr_match #(
  parameter int               HDR_W       = 4,
  parameter logic [HDR_W-1:0] HDR_PATTERN = 4'b1010
) (
  input  logic [HDR_W-1:0] hdr_bits,
  output logic             hdr_ok
);
  assign hdr_ok = (hdr_bits == HDR_PATTERN);
endmodule

// File: rtl/fa_lock_fsm.sv
module fa_lock_fsm
  import fa_pkg::*;
#(
  parameter int W              = 40,
  parameter int FRAME_WORDS    = 3,
  parameter int CONFIRM_FRAMES = 32,
  parameter int LOSS_FRAMES    = 4,
  localparam int SLIP_W = $clog2(W),
  localparam int IDX_W  = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1,
  localparam int CNT_W  = $clog2(CONFIRM_FRAMES + 1),
  localparam int MISS_W = $clog2(LOSS_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_ok,
  output logic [SLIP_W-1:0] slip,
  output logic [IDX_W-1:0]  phase,
  output fa_state_e         state
);
  localparam logic [SLIP_W-1:0] SLIP_LAST = SLIP_W'(W - 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(FRAME_WORDS - 1);
  localparam logic [IDX_W-1:0]  IDX_AFTER = IDX_W'(1 % FRAME_WORDS);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(CONFIRM_FRAMES - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_FRAMES - 1);

  fa_state_e         state_q, state_d;
  logic [SLIP_W-1:0] slip_q, slip_d;
  logic [IDX_W-1:0]  phase_q, phase_d, phase_inc;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              frame_chk;

  always_comb begin
    phase_inc = (phase_q == IDX_LAST) ? '0 : phase_q + 1'b1;
    frame_chk = (phase_q == '0);
    state_d   = state_q;
    slip_d    = slip_q;
    phase_d   = phase_inc;
    cnt_d     = cnt_q;
    miss_d    = miss_q;
    unique case (state_q)
      ST_SEARCH: begin
        phase_d = phase_q;
        if (hdr_ok) begin
          state_d = ST_CONFIRM;
          phase_d = IDX_AFTER;
          cnt_d   = '0;
        end else begin
          slip_d = (slip_q == SLIP_LAST) ? '0 : slip_q + 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (frame_chk) begin
          if (!hdr_ok) begin
            state_d = ST_SEARCH;
            cnt_d   = '0;
          end else if (cnt_q == CNT_LAST) begin
            state_d = ST_LOCKED;
            cnt_d   = '0;
            miss_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_LOCKED: begin
        if (frame_chk) begin
          if (hdr_ok) begin
            miss_d = '0;
          end else if (miss_q == MISS_LAST) begin
            state_d = ST_SEARCH;
            miss_d  = '0;
          end else begin
            miss_d = miss_q + 1'b1;
          end
        end
      end
      default: state_d = ST_SEARCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      slip_q  <= '0;
      phase_q <= '0;
      cnt_q   <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      slip_q  <= slip_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      miss_q  <= miss_d;
    end
  end

  assign slip  = slip_q;
  assign phase = phase_q;
  assign state = state_q;
endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
  import fa_pkg::*;
#(
  parameter int               W              = 40,
  parameter int               FRAME_WORDS    = 3,
  parameter int               HDR_W          = 4,
  parameter logic [HDR_W-1:0] HDR_PATTERN    = 4'b1010,
  parameter int               CONFIRM_FRAMES = 32,
  parameter int               LOSS_FRAMES    = 4,
  localparam int SLIP_W = $clog2(W),
  localparam int IDX_W  = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     rx_word,
  output logic [W-1:0]     al_word,
  output logic [IDX_W-1:0] word_idx,
  output logic             frame_start,
  output logic             locked
);
  logic [W-1:0]      aligned_w;
  logic              hdr_ok_w;
  logic [SLIP_W-1:0] slip_w;
  logic [IDX_W-1:0]  phase_w;
  fa_state_e         state_w;
  logic              out_en;

  fa_slip_shifter #(.W(W), .SLIP_W(SLIP_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .slip(slip_w), .aligned(aligned_w)
  );

  fa_hdr_match #(.HDR_W(HDR_W), .HDR_PATTERN(HDR_PATTERN)) u_hdr (
    .hdr_bits(aligned_w[HDR_W-1:0]), .hdr_ok(hdr_ok_w)
  );

  fa_lock_fsm #(
    .W(W), .FRAME_WORDS(FRAME_WORDS),
    .CONFIRM_FRAMES(CONFIRM_FRAMES), .LOSS_FRAMES(LOSS_FRAMES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .hdr_ok(hdr_ok_w),
    .slip(slip_w), .phase(phase_w), .state(state_w)
  );

  // word stream never stalls, so the output stage is always enabled
  assign out_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_word     <= '0;
      word_idx    <= '0;
      frame_start <= 1'b0;
    end else if (out_en) begin
      al_word     <= aligned_w;
      word_idx    <= phase_w;
      frame_start <= (state_w == ST_LOCKED) && (phase_w == '0);
    end
  end

  assign locked = (state_w == ST_LOCKED);
endmodule

// File: rtl/fa_checker.sv
module fa_checker
  import fa_pkg::*;
#(
  parameter int IDX_W       = 2,
  parameter int SLIP_W      = 6,
  parameter int FRAME_WORDS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              locked,
  input logic              frame_start,
  input logic [IDX_W-1:0]  word_idx,
  input logic              hdr_ok,
  input logic [SLIP_W-1:0] slip,
  input logic [IDX_W-1:0]  phase,
  input logic [1:0]        state
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_WORDS - 1);

  AST_SEARCH_SLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH && !hdr_ok) |=> !$stable(slip)); // R3

  AST_SLIP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_SEARCH) |=> $stable(slip)); // R9

  AST_LOCK_FROM_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(state) == ST_CONFIRM && $past(hdr_ok))); // R5

  AST_CONFIRM_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONFIRM && phase == '0 && !hdr_ok) |=> (state == ST_SEARCH)); // R6

  AST_IDX_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (word_idx == (($past(word_idx) == IDX_LAST) ? '0 : $past(word_idx) + 1'b1))); // R7

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (word_idx == '0)); // R7

  AST_LOSS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> !$past(hdr_ok)); // R8
endmodule

bind frame_aligner fa_checker #(
  .IDX_W(IDX_W), .SLIP_W(SLIP_W), .FRAME_WORDS(FRAME_WORDS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .locked(locked), .frame_start(frame_start),
  .word_idx(word_idx), .hdr_ok(hdr_ok_w), .slip(slip_w), .phase(phase_w),
  .state(state_w)
);

// File: tb/sim_frame_aligner.sv
module sim_frame_aligner;
  localparam int FR = 320;

  logic        clk;
  logic        rst_n;
  logic [39:0] rx_word;
  logic [39:0] al_word;
  logic [1:0]  word_idx;
  logic        frame_start;
  logic        locked;

  int checks = 0;
  int fails  = 0;
  int kofs   = 0;
  logic [119:0] frames [0:FR-1];

  frame_aligner u0 (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .al_word(al_word),
    .word_idx(word_idx), .frame_start(frame_start), .locked(locked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic sbit(int i);
    int j;
    if (i < kofs) return 1'b0;
    j = i - kofs;
    if (j / 120 >= FR) return 1'b0;
    return frames[j / 120][j % 120];
  endfunction

  function automatic logic [39:0] win(int p);
    logic [39:0] v;
    for (int b = 0; b < 40; b++) v[b] = sbit(p + b);
    return v;
  endfunction

  // first word where the searching window lands on a header
  function automatic int first_hit();
    for (int t = 0; t < 400; t++) begin
      int p;
      p = 40 * (t - 1) + (t % 40);
      if (p >= kofs && ((p - kofs) % 120) == 0) return t;
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [39:0] w);
    rx_word = w;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    rx_word = '0;
    repeat (3) @(negedge clk);
    chk(locked == 1'b0 && frame_start == 1'b0, "R1 status", {locked, frame_start}, 0);
    chk(word_idx == 2'd0 && al_word == 40'd0, "R1 data", {word_idx, al_word}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_dir(input int k, input bit cfault);
    int t0, p0, n0, lf, tend;
    kofs = k;
    for (int n = 0; n < FR; n++) frames[n] = 120'hA;
    t0 = first_hit();
    p0 = 40 * (t0 - 1) + (t0 % 40);
    n0 = (p0 - k) / 120;
    lf = n0 + 33;
    if (cfault) begin
      frames[n0 + 5][3:0] = 4'h0;
      tend = t0 + 400;
    end else begin
      for (int m = 1; m <= 3; m++)  frames[lf + m][3:0] = 4'h0;
      for (int m = 5; m <= 7; m++)  frames[lf + m][3:0] = 4'h0;
      for (int m = 10; m <= 13; m++) frames[lf + m][3:0] = 4'h0;
      tend = t0 + 3 * (lf + 13 - n0);
    end
    do_reset();
    for (int t = 0; t <= tend; t++) begin
      step(win(40 * t));
      if (t < t0) chk(al_word == win(40 * (t - 1) + (t % 40)), "R3 slip window", al_word, win(40 * (t - 1) + (t % 40)));
      if (t == t0) begin
        chk(al_word[3:0] == 4'b1010, "R2 header bits", al_word[3:0], 4'b1010);
        chk(locked == 1'b0, "R4 no lock at first match", locked, 0);
      end
      if (!cfault) begin
        if (t == t0 + 95) chk(locked == 1'b0, "R5 early", locked, 0);
        if (t == t0 + 96) chk(locked == 1'b1, "R5 lock time", locked, 1);
        if (t == t0 + 99) chk(frame_start && word_idx == 2'd0, "R7 start", {frame_start, word_idx}, 3'b100);
        if (t == t0 + 100) chk(!frame_start && word_idx == 2'd1, "R7 idx1", {frame_start, word_idx}, 3'b001);
        if (t == t0 + 101) chk(!frame_start && word_idx == 2'd2, "R7 idx2", {frame_start, word_idx}, 3'b010);
        if (t == t0 + 3 * (lf + 3 - n0))  chk(locked == 1'b1, "R8 three misses", locked, 1);
        if (t == t0 + 3 * (lf + 7 - n0))  chk(locked == 1'b1, "R8 run cleared", locked, 1);
        if (t == t0 + 3 * (lf + 12 - n0)) chk(locked == 1'b1, "R8 third of four", locked, 1);
        if (t == t0 + 3 * (lf + 13 - n0)) chk(locked == 1'b0, "R8 fourth miss", locked, 0);
      end else begin
        if (t == t0 + 96) chk(locked == 1'b0, "R6 no lock after confirm miss", locked, 0);
        if (t == tend) chk(locked == 1'b1, "R6 relock", locked, 1);
      end
    end
  endtask

  task automatic run_rnd(input int k);
    int expn, pos, seen;
    logic [39:0] w0, w1, w2;
    logic [119:0] fr;
    kofs = k;
    for (int n = 0; n < FR; n++) begin
      fr = {$urandom(), $urandom(), $urandom(), $urandom()};
      fr[3:0] = 4'hA;
      frames[n] = fr;
    end
    expn = -1; pos = -1; seen = 0;
    w0 = '0; w1 = '0; w2 = '0;
    do_reset();
    for (int t = 0; t < 900; t++) begin
      step(win(40 * t));
      if (locked) seen = 1;
      if (frame_start) begin
        chk(word_idx == 2'd0, "R7 start idx", word_idx, 0);
        w0 = al_word; pos = 1;
      end else if (pos == 1) begin
        chk(word_idx == 2'd1, "R7 idx1", word_idx, 1);
        w1 = al_word; pos = 2;
      end else if (pos == 2) begin
        chk(word_idx == 2'd2, "R7 idx2", word_idx, 2);
        w2 = al_word; pos = -1;
        fr = {w2, w1, w0};
        if (expn < 0) begin
          for (int n = 0; n < FR; n++) if (frames[n] == fr) expn = n;
          chk(expn >= 0, "R7 frame found", fr, 0);
          if (expn >= 0) expn++;
        end else begin
          chk(fr == frames[expn], "R7 frame order", fr, frames[expn]);
          expn++;
        end
      end
    end
    chk(seen == 1, "R5 random lock", seen, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    rst_n   = 1'b0;
    rx_word = '0;
    run_dir(0, 1'b0);
    run_dir(37, 1'b0);
    run_dir(119, 1'b0);
    run_dir(79, 1'b0);
    run_dir(50, 1'b1);
    for (int r = 0; r < 3; r++) run_rnd(int'($urandom_range(119, 0)));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule